// File: doc/BRIEF.md
# RGMII Frame Player with In-Band Gaps

This block plays prepared Ethernet traffic onto the receive side of one RGMII link. A local buffer holds 9-bit entries. A high tag bit marks a frame byte. A low tag bit opens a gap record: that entry and the three after it carry a 32-bit idle length, most significant byte first. Frame bytes leave the block as a pair of nibbles per clock with the control line high. The pair goes to an external double-data-rate output cell: the low nibble on the rising half and the high nibble on the falling half. Gap records hold data and control at zero for a measured number of cycles.

The buffer is filled through an append-only stream port. An entry is accepted in any cycle where `wr_valid` and `wr_ready` are both high. `wr_ready` falls once the buffer is full, and the producer must then hold or drop its entry. An entry offered while `wr_ready` is low is discarded and sets a sticky overflow flag. Playback may run while the buffer is being filled. The read pointer follows the write count and stops when it catches up with it. The stored frames are expected to start with the usual seven 0x55 bytes and one 0xD5 byte. These are sent like any other frame byte.

Top module: `rgmii_frame_player`

## Requirements
- R1: After reset, `rgmii_ctl`, `rgmii_d_rise` and `rgmii_d_fall` are 0, `wr_count` is 0, `wr_ready` is 1 and `wr_overflow` is 0. With an empty buffer, the outputs stay 0 after `play_en` rises.
- R2: An entry with bit 8 = 1 is a frame byte. It produces one cycle with `rgmii_ctl` = 1, `rgmii_d_rise` = bits 3:0 and `rgmii_d_fall` = bits 7:4. The bytes appear one per cycle, in buffer order, in the cycle after the edge that reads them.
- R3: An entry with bit 8 = 0 at the read pointer, with no gap running, starts a gap record. Its bits 7:0 and those of the next three entries form a count N, first entry most significant. The pointer moves on by 4, and the block then shows exactly N+1 cycles with control and data at 0 before the next entry plays.
- R4: A gap record is not started until all four of its entries are in the buffer. Until then the outputs hold their values.
- R5: While `play_en` is 0 at a clock edge, the next cycle shows control and data at 0. The read pointer and the gap countdown are frozen, so playback resumes with no byte lost or repeated.
- R6: When the read pointer equals `wr_count`, the outputs hold their last values. An entry appended later plays in the cycle after the edge that reads it.
- R7: Each accepted write stores the entry at position `wr_count` and increments `wr_count`. `wr_ready` is 0 exactly when `wr_count` equals the buffer depth.
- R8: `wr_valid` while `wr_ready` is 0 leaves `wr_count` unchanged and sets `wr_overflow`, which stays set until reset.
- R9: Preamble bytes (seven 0x55 followed by 0xD5, tagged as frame data) are sent unchanged with `rgmii_ctl` high, with no special handling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| play_en | input | 1 | Port enable, sampled at each rising edge |
| wr_valid | input | 1 | Buffer append request |
| wr_ready | output | 1 | Buffer has space |
| wr_data | input | 9 | Entry: bit 8 tag (1 frame byte, 0 gap byte), bits 7:0 value |
| wr_count | output | CW (9) | Number of entries written |
| wr_overflow | output | 1 | Sticky: a write was offered while full |
| rgmii_d_rise | output | 4 | Nibble for the rising half of the cycle |
| rgmii_d_fall | output | 4 | Nibble for the falling half of the cycle |
| rgmii_ctl | output | 1 | Data-valid control line |

## Verification
An internal error shows at the ports within a cycle or two. A misplaced read pointer puts a wrong byte on the nibble pair in the very next cycle. A gap counter that is loaded or decremented wrongly changes the measured idle length, which the checks compare to N+1 exactly. A reversed byte order in the gap record turns a short gap into one of tens of millions of cycles and is caught by the run limit. A pointer or counter that is not frozen while disabled shows up as a missing or repeated byte once playback resumes.

// File: rtl/rfp_pkg.sv
package rfp_pkg;
  localparam int ENTRY_W = 9;
  localparam int TAG_BIT = 8;
  typedef logic [ENTRY_W-1:0] entry_t;

  // What the sequencer does at one clock edge.
  typedef enum logic [2:0] {
    ACT_OFF,    // port disabled: drive zeros, freeze
    ACT_COUNT,  // gap running: drive zeros, count down
    ACT_BYTE,   // send one frame byte as two nibbles
    ACT_LOAD,   // take in a gap record
    ACT_HOLD    // nothing playable: keep outputs
  } act_e;
endpackage

// File: rtl/rfp_buffer.sv
module rfp_buffer
  import rfp_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int LOOK  = 4,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_valid,
  input  entry_t                        wr_data,
  output logic                          wr_ready,
  output logic [CW-1:0]                 wr_count,
  output logic                          wr_overflow,
  input  logic [CW-1:0]                 rd_base,
  output logic [LOOK-1:0][ENTRY_W-1:0]  rd_entries
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  entry_t mem [DEPTH];
  logic   accept;

  assign wr_ready = (wr_count != CW'(DEPTH));
  assign accept   = wr_valid && wr_ready;

  always_ff @(posedge clk) begin
    if (accept) mem[wr_count[AW-1:0]] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_count    <= '0;
      wr_overflow <= 1'b0;
    end else begin
      if (accept) wr_count <= wr_count + 1'b1;
      if (wr_valid && !wr_ready) wr_overflow <= 1'b1;
    end
  end

  // Look-ahead read ports: the head entry and the ones after it.
  logic [LOOK-1:0][CW-1:0] idx;
  logic [LOOK-1:0]         unused_idx_hi;
  for (genvar k = 0; k < LOOK; k++) begin : g_look
    assign idx[k]           = rd_base + CW'(k);
    assign rd_entries[k]    = mem[idx[k][AW-1:0]];
    assign unused_idx_hi[k] = ^idx[k];
  end

  // R7: a refused write leaves the count alone
  p_full_refuse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_count == $past(wr_count));
  // R7: an accepted write advances the count by one
  p_count_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && wr_ready |=> wr_count == $past(wr_count) + 1'b1);
  // R8: overflow flag never clears outside reset
  p_overflow_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_overflow |=> wr_overflow);
endmodule

// File: rtl/rfp_sequencer.sv
module rfp_sequencer
  import rfp_pkg::*;
#(
  parameter int CW   = 9,
  parameter int LOOK = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          play_en,
  input  logic [CW-1:0]                 wr_count,
  input  logic [LOOK-1:0][ENTRY_W-1:0]  ent,
  output logic [CW-1:0]                 rd_ptr,
  output logic [3:0]                    d_rise,
  output logic [3:0]                    d_fall,
  output logic                          ctl
);
  localparam int GAP_W = 8 * LOOK;

  logic [CW-1:0]    avail;
  logic [GAP_W-1:0] gap_value;
  logic [GAP_W-1:0] gap_cnt;
  logic             head_is_data;
  act_e             act;
  logic             unused_tags;

  assign avail        = wr_count - rd_ptr;
  assign head_is_data = ent[0][TAG_BIT];

  // Gap record: first entry is the most significant byte.
  always_comb begin
    gap_value   = '0;
    unused_tags = 1'b0;
    for (int k = 0; k < LOOK; k++) begin
      gap_value[GAP_W-1-8*k -: 8] = ent[k][7:0];
      unused_tags = unused_tags ^ ent[k][TAG_BIT];
    end
  end

  always_comb begin
    if (!play_en)                                 act = ACT_OFF;
    else if (gap_cnt != '0)                       act = ACT_COUNT;
    else if (avail != '0 && head_is_data)         act = ACT_BYTE;
    else if (avail >= CW'(LOOK) && !head_is_data) act = ACT_LOAD;
    else                                          act = ACT_HOLD;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr  <= '0;
      gap_cnt <= '0;
      d_rise  <= '0;
      d_fall  <= '0;
      ctl     <= 1'b0;
    end else begin
      unique case (act)
        ACT_OFF: begin
          d_rise <= '0; d_fall <= '0; ctl <= 1'b0;
        end
        ACT_COUNT: begin
          gap_cnt <= gap_cnt - 1'b1;
          d_rise <= '0; d_fall <= '0; ctl <= 1'b0;
        end
        ACT_BYTE: begin
          d_rise <= ent[0][3:0];
          d_fall <= ent[0][7:4];
          ctl    <= 1'b1;
          rd_ptr <= rd_ptr + 1'b1;
        end
        ACT_LOAD: begin
          gap_cnt <= gap_value;
          rd_ptr  <= rd_ptr + CW'(LOOK);
          d_rise <= '0; d_fall <= '0; ctl <= 1'b0;
        end
        default: ;
      endcase
    end
  end

  // R6: the pointer never passes the write count
  p_ptr_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ptr <= wr_count);
  // R3: nothing is sent while a gap is counting
  p_gap_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    gap_cnt != '0 |-> !ctl && d_rise == '0 && d_fall == '0);
  // R5: a disabled edge yields a quiet cycle
  p_disabled_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !play_en |=> !ctl && d_rise == '0 && d_fall == '0);
  // R5: pointer and countdown frozen while disabled
  p_disabled_freeze_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !play_en |=> $stable(rd_ptr) && $stable(gap_cnt));
  // R6: caught up with the writer, outputs hold
  p_stop_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    play_en && gap_cnt == '0 && rd_ptr == wr_count
      |=> $stable(ctl) && $stable(d_rise) && $stable(d_fall));
endmodule

// File: rtl/rgmii_frame_player.sv
module rgmii_frame_player
  import rfp_pkg::*;
#(
  parameter int DEPTH     = 256,
  parameter int GAP_BYTES = 4,
  parameter int CW        = $clog2(DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                play_en,
  input  logic                wr_valid,
  output logic                wr_ready,
  input  logic [ENTRY_W-1:0]  wr_data,
  output logic [CW-1:0]       wr_count,
  output logic                wr_overflow,
  output logic [3:0]          rgmii_d_rise,
  output logic [3:0]          rgmii_d_fall,
  output logic                rgmii_ctl
);
  logic [CW-1:0]                      rd_ptr;
  logic [GAP_BYTES-1:0][ENTRY_W-1:0]  look;

  rfp_buffer #(.DEPTH(DEPTH), .LOOK(GAP_BYTES), .CW(CW)) u_buf (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_valid    (wr_valid),
    .wr_data     (wr_data),
    .wr_ready    (wr_ready),
    .wr_count    (wr_count),
    .wr_overflow (wr_overflow),
    .rd_base     (rd_ptr),
    .rd_entries  (look)
  );

  rfp_sequencer #(.CW(CW), .LOOK(GAP_BYTES)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .play_en  (play_en),
    .wr_count (wr_count),
    .ent      (look),
    .rd_ptr   (rd_ptr),
    .d_rise   (rgmii_d_rise),
    .d_fall   (rgmii_d_fall),
    .ctl      (rgmii_ctl)
  );

  // R1: outputs quiet in the first cycle after reset
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |=> !rgmii_ctl && wr_count == '0 && !wr_overflow);
endmodule

// File: tb/rgmii_frame_player_bench.sv
module rgmii_frame_player_bench;
  localparam int DEPTH = 256;
  localparam int CW    = $clog2(DEPTH + 1);

  logic          clk = 1'b0;
  logic          rst_n, play_en, wr_valid, wr_ready, wr_overflow, rgmii_ctl;
  logic [8:0]    wr_data;
  logic [CW-1:0] wr_count;
  logic [3:0]    rgmii_d_rise, rgmii_d_fall;

  always #2 clk = ~clk;

  rgmii_frame_player #(.DEPTH(DEPTH)) u_rgmii_frame_player (
    .clk(clk), .rst_n(rst_n), .play_en(play_en), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_data(wr_data), .wr_count(wr_count),
    .wr_overflow(wr_overflow), .rgmii_d_rise(rgmii_d_rise),
    .rgmii_d_fall(rgmii_d_fall), .rgmii_ctl(rgmii_ctl)
  );

  int   tests = 0, fails = 0;
  bit   finished = 0;
  logic [7:0] cap_b [0:299];
  logic       cap_c [0:299];

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 0; play_en = 0; wr_valid = 0; wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic push(input logic [8:0] e);
    wr_valid = 1; wr_data = e;
    @(negedge clk);
    wr_valid = 0;
  endtask

  task automatic capture(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cap_c[i] = rgmii_ctl;
      cap_b[i] = {rgmii_d_fall, rgmii_d_rise};
    end
  endtask

  task automatic t_reset();
    do_reset();
    chk(!rgmii_ctl && rgmii_d_rise == 0 && rgmii_d_fall == 0, "R1 outputs", rgmii_ctl, 0);
    chk(wr_count == 0 && wr_ready && !wr_overflow, "R1 write side", wr_count, 0);
    play_en = 1;
    capture(3);
    chk(!cap_c[2] && cap_b[2] == 0, "R1 empty enabled", cap_c[2], 0);
  endtask

  task automatic t_frame();
    logic [7:0] exp_b [0:11];
    int bad;
    do_reset();
    for (int i = 0; i < 7; i++) exp_b[i] = 8'h55;
    exp_b[7] = 8'hD5; exp_b[8] = 8'hA5; exp_b[9] = 8'h3C;
    exp_b[10] = 8'h01; exp_b[11] = 8'hF0;
    for (int i = 0; i < 12; i++) push({1'b1, exp_b[i]});
    play_en = 1;
    capture(14);
    bad = 0;
    for (int i = 0; i < 8; i++) if (!cap_c[i] || cap_b[i] != exp_b[i]) bad++;
    chk(bad == 0, "R9 preamble bytes", bad, 0);
    bad = 0;
    for (int i = 8; i < 12; i++) if (!cap_c[i] || cap_b[i] != exp_b[i]) bad++;
    chk(bad == 0, "R2 payload order", bad, 0);
    chk(cap_b[8][3:0] == 4'h5 && cap_b[8][7:4] == 4'hA, "R2 nibble halves", cap_b[8], 8'hA5);
    chk(cap_c[12] && cap_c[13] && cap_b[13] == 8'hF0, "R6 hold at end", cap_b[13], 8'hF0);
    push(9'h1E7);
    capture(2);
    chk(cap_c[0] && cap_b[0] == 8'hE7, "R6 late append", cap_b[0], 8'hE7);
  endtask

  task automatic t_gap();
    int idle;
    do_reset();
    push(9'h111); push(9'h122);
    push(9'h000); push(9'h000); push(9'h000); push(9'h005);
    push(9'h133);
    play_en = 1;
    capture(10);
    chk(cap_c[0] && cap_b[0] == 8'h11 && cap_c[1] && cap_b[1] == 8'h22, "R3 bytes before gap", cap_b[1], 8'h22);
    idle = 0;
    for (int i = 2; i < 8; i++) if (!cap_c[i] && cap_b[i] == 0) idle++;
    chk(idle == 6, "R3 gap of 5 idles 6", idle, 6);
    chk(cap_c[8] && cap_b[8] == 8'h33, "R3 byte after gap", cap_b[8], 8'h33);
  endtask

  task automatic t_big_gap();
    int first;
    do_reset();
    push(9'h144);
    push(9'h000); push(9'h000); push(9'h001); push(9'h003);
    push(9'h155);
    play_en = 1;
    capture(270);
    first = -1;
    for (int i = 1; i < 270; i++) if (first < 0 && cap_c[i]) first = i;
    chk(first == 261, "R3 MSB-first count 0x103", first, 261);
    chk(first > 0 && cap_b[first] == 8'h55, "R3 byte after long gap", first > 0 ? cap_b[first] : 0, 8'h55);
  endtask

  task automatic t_partial();
    do_reset();
    push(9'h000); push(9'h000);
    play_en = 1;
    capture(5);
    chk(!cap_c[4] && cap_b[4] == 0, "R4 partial record waits", cap_c[4], 0);
    push(9'h000); push(9'h002); push(9'h166);
    capture(4);
    chk(!cap_c[0] && !cap_c[1], "R4 gap of 2 after completion", {cap_c[0], cap_c[1]}, 0);
    chk(cap_c[2] && cap_b[2] == 8'h66, "R4 byte after record", cap_b[2], 8'h66);
  endtask

  task automatic t_enable();
    int bad;
    logic [7:0] exp;
    logic       en_exp;
    do_reset();
    for (int i = 0; i < 8; i++) push({1'b1, 8'h10 + 8'(i)});
    play_en = 1;
    bad = 0;
    for (int i = 0; i < 14; i++) begin
      @(negedge clk);
      en_exp = !(i >= 3 && i < 7);
      if (!en_exp) exp = 8'h00;
      else if (i < 3) exp = 8'h10 + 8'(i);
      else if (i < 12) exp = 8'h10 + 8'(i - 4);
      else exp = 8'h17;
      if (rgmii_ctl != en_exp || {rgmii_d_fall, rgmii_d_rise} != exp) begin
        bad++;
        $display("FAIL R5 cycle %0d actual=%0h expected=%0h", i, {rgmii_d_fall, rgmii_d_rise}, exp);
      end
      play_en = !((i + 1) >= 3 && (i + 1) < 7);
    end
    chk(bad == 0, "R5 disable freezes and resumes", bad, 0);
  endtask

  task automatic t_overflow();
    do_reset();
    for (int i = 0; i < DEPTH - 1; i++) push({1'b1, 8'(i)});
    chk(wr_ready && wr_count == CW'(DEPTH - 1), "R7 ready below full", wr_count, DEPTH - 1);
    push(9'h1AA);
    chk(!wr_ready && wr_count == CW'(DEPTH) && !wr_overflow, "R7 full", wr_count, DEPTH);
    push(9'h1BB);
    chk(wr_overflow && wr_count == CW'(DEPTH), "R8 refused write flagged", wr_overflow, 1);
    repeat (3) @(negedge clk);
    chk(wr_overflow, "R8 flag sticky", wr_overflow, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_frame();
    t_gap();
    t_big_gap();
    t_partial();
    t_enable();
    t_overflow();
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule